// File: doc/BRIEF.md
# DMA Channel Transfer Status Tracker

This block keeps the transfer status of one DMA channel that moves data from a source peripheral, through a channel FIFO, to a destination peripheral. While a block transfer is active, it counts the source-width data items that the destination accepts. When the block ends, it fixes two results:

- the number of items delivered;
- the number of whole source-width items still stranded in the FIFO.

A block that completes cleanly reports the programmed block size and an empty residue. A block cut short by an error reports its partial progress and what it left behind.

Both results are packed into a 64-bit read-only status word. A register read port returns that word one cycle after a read request. Enabling the channel again clears both fields and opens a new block. The FIFO itself, bus protocol and arbitration are outside this block. The block only observes occupancy, beat strobes and end-of-block indications.

Top module: `dma_xfer_status`

## Requirements
- R1: The status word is 64 bits. Bits 21:0 hold the delivered-item count and bits 46:32 hold the FIFO residue. Bits 31:22 and 63:47 always read zero.
- R2: Both fields are zero after reset. Both return to zero on every rising edge of `ch_en` (0 then 1 on consecutive clocks), and that edge opens a new active block.
- R3: During an active block, each cycle with `dst_beat` high adds one to the count. Beats when no block is active are ignored. A beat in the cycle that ends the block is not counted.
- R4: The count saturates at its all-ones maximum (2^CNT_W - 1) and never wraps.
- R5: When `blk_done` ends an active block without `blk_err`, the count becomes the `blk_size` value present in that cycle and the residue becomes zero.
- R6: When `blk_err` ends an active block, the count keeps the beats delivered before that cycle. The residue captures `floor(fifo_bytes / 2^src_wcode)`, where `src_wcode` is log2 of the source item size in bytes. If `blk_done` is high in the same cycle, the error takes priority.
- R7: If `dst_wcode > src_wcode` and `fifo_bytes` is less than one source item, the captured residue is zero. A residue larger than the field clamps to the all-ones value.
- R8: After a block ends, both fields hold until the next rising edge of `ch_en`. `dst_beat`, `blk_done` and `blk_err` have no effect while no block is active. Dropping `ch_en` ends the active block.
- R9: A read request on `rd_en` puts the current status word on `rd_data` at the next clock edge. `rd_data` holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 1 | Channel enable level; a rising edge starts a block |
| dst_beat | input | 1 | One source-width item accepted by the destination |
| blk_done | input | 1 | Block finished normally |
| blk_err | input | 1 | Block terminated by an error |
| blk_size | input | CNT_W (22) | Programmed block size in source items |
| fifo_bytes | input | BYTE_W (18) | Channel FIFO occupancy in bytes |
| src_wcode | input | WCODE_W (3) | log2 of source item size in bytes |
| dst_wcode | input | WCODE_W (3) | log2 of destination item size in bytes |
| rd_en | input | 1 | Status read request |
| rd_data | output | 64 | Status word, registered |

## Verification
Some internal faults would only show up at `rd_data` on the first read after the block ends:

- a count that misses a beat or counts outside the active window;
- an event decoder that gives the wrong priority to a simultaneous done and error;
- a residue captured at the wrong width shift.

Each of those reads therefore carries a computed expectation. A lost clear on enable shows up on the first read of the next block. A broken saturation only shows up after the counter reaches its maximum, so a narrow-counter instance reaches that edge within a few dozen beats. A read path with the wrong latency returns the previous word, and the one-cycle scoreboard compare catches that at once.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
   typedef enum logic [1:0] {
      EV_NONE    = 2'd0,
      EV_START   = 2'd1,
      EV_END_OK  = 2'd2,
      EV_END_ERR = 2'd3
   } blk_event_e;
endpackage

// File: rtl/dst_beat_counter.sv
module dst_beat_counter
   import dma_stat_pkg::*;
#(
   parameter int CNT_W    = 22,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  blk_event_e       evt,
   input  logic             active,
   input  logic             beat,
   input  logic [CNT_W-1:0] blk_size,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] count_inc;

   generate
      if (SATURATE) begin : g_sat
         always_comb count_inc = (count == CNT_MAX) ? count : count + CNT_ONE;
      end else begin : g_wrap
         always_comb count_inc = count + CNT_ONE;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else begin
         unique case (evt)
            EV_START:   count <= '0;
            EV_END_OK:  count <= blk_size;
            EV_END_ERR: count <= count;
            default:    if (active && beat) count <= count_inc;
         endcase
      end
   end
endmodule

// File: rtl/fifo_residue_capture.sv
module fifo_residue_capture
   import dma_stat_pkg::*;
#(
   parameter int RES_W   = 15,
   parameter int BYTE_W  = 18,
   parameter int WCODE_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  blk_event_e         evt,
   input  logic [BYTE_W-1:0]  fifo_bytes,
   input  logic [WCODE_W-1:0] src_wcode,
   input  logic [WCODE_W-1:0] dst_wcode,
   output logic [RES_W-1:0]   residue
);
   localparam logic [BYTE_W-1:0] BYTE_ONE = {{(BYTE_W-1){1'b0}}, 1'b1};

   logic [BYTE_W-1:0] item_bytes;
   logic [BYTE_W-1:0] whole_items;
   logic              frag_only;
   logic [RES_W-1:0]  items_fit;

   always_comb begin
      item_bytes  = BYTE_ONE << src_wcode;
      whole_items = fifo_bytes >> src_wcode;
      frag_only   = (dst_wcode > src_wcode) && (fifo_bytes < item_bytes);
   end

   generate
      if (BYTE_W > RES_W) begin : g_clamp
         always_comb items_fit = (|whole_items[BYTE_W-1:RES_W]) ?
                                 {RES_W{1'b1}} : whole_items[RES_W-1:0];
      end else if (BYTE_W == RES_W) begin : g_same
         always_comb items_fit = whole_items;
      end else begin : g_extend
         always_comb items_fit = {{(RES_W-BYTE_W){1'b0}}, whole_items};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         residue <= '0;
      end else begin
         unique case (evt)
            EV_START, EV_END_OK: residue <= '0;
            EV_END_ERR:          residue <= frag_only ? '0 : items_fit;
            default:             residue <= residue;
         endcase
      end
   end
endmodule

// File: rtl/status_read_port.sv
module status_read_port #(
   parameter int WORD_W  = 64,
   parameter int CNT_W   = 22,
   parameter int RES_W   = 15,
   parameter int CNT_LSB = 0,
   parameter int RES_LSB = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  count,
   input  logic [RES_W-1:0]  residue,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] word;

   always_comb begin
      word = '0;
      word[CNT_LSB +: CNT_W] = count;
      word[RES_LSB +: RES_W] = residue;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= word;
   end
endmodule

// File: rtl/dma_xfer_status.sv
module dma_xfer_status
   import dma_stat_pkg::*;
#(
   parameter int WORD_W   = 64,
   parameter int CNT_W    = 22,
   parameter int RES_W    = 15,
   parameter int CNT_LSB  = 0,
   parameter int RES_LSB  = 32,
   parameter int BYTE_W   = 18,
   parameter int WCODE_W  = 3,
   parameter bit SATURATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ch_en,
   input  logic               dst_beat,
   input  logic               blk_done,
   input  logic               blk_err,
   input  logic [CNT_W-1:0]   blk_size,
   input  logic [BYTE_W-1:0]  fifo_bytes,
   input  logic [WCODE_W-1:0] src_wcode,
   input  logic [WCODE_W-1:0] dst_wcode,
   input  logic               rd_en,
   output logic [WORD_W-1:0]  rd_data
);
   generate
      if (CNT_LSB + CNT_W > RES_LSB) begin : g_bad_overlap
         $error("count field overlaps residue field");
      end
      if (RES_LSB + RES_W > WORD_W) begin : g_bad_word
         $error("residue field exceeds status word");
      end
      if (CNT_W < 2 || RES_W < 1) begin : g_bad_width
         $error("field widths too small");
      end
   endgenerate

   logic       ch_en_q;
   logic       en_rise;
   logic       blk_active;
   blk_event_e evt;
   logic [CNT_W-1:0] count;
   logic [RES_W-1:0] residue;

   always_comb begin
      en_rise = ch_en && !ch_en_q;
      if (en_rise)                      evt = EV_START;
      else if (blk_active && blk_err)   evt = EV_END_ERR;
      else if (blk_active && blk_done)  evt = EV_END_OK;
      else                              evt = EV_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_en_q    <= 1'b0;
         blk_active <= 1'b0;
      end else begin
         ch_en_q <= ch_en;
         if (evt == EV_START)                          blk_active <= 1'b1;
         else if (evt != EV_NONE || !ch_en)            blk_active <= 1'b0;
      end
   end

   dst_beat_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_count (
      .clk(clk), .rst_n(rst_n), .evt(evt), .active(blk_active),
      .beat(dst_beat), .blk_size(blk_size), .count(count)
   );

   fifo_residue_capture #(.RES_W(RES_W), .BYTE_W(BYTE_W), .WCODE_W(WCODE_W)) u_res (
      .clk(clk), .rst_n(rst_n), .evt(evt), .fifo_bytes(fifo_bytes),
      .src_wcode(src_wcode), .dst_wcode(dst_wcode), .residue(residue)
   );

   status_read_port #(.WORD_W(WORD_W), .CNT_W(CNT_W), .RES_W(RES_W),
                      .CNT_LSB(CNT_LSB), .RES_LSB(RES_LSB)) u_read (
      .clk(clk), .rst_n(rst_n), .count(count), .residue(residue),
      .rd_en(rd_en), .rd_data(rd_data)
   );
endmodule

// File: rtl/dma_xfer_status_chk.sv
module dma_xfer_status_chk #(
   parameter int WORD_W   = 64,
   parameter int CNT_W    = 22,
   parameter int RES_W    = 15,
   parameter int CNT_LSB  = 0,
   parameter int RES_LSB  = 32,
   parameter bit SATURATE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ch_en,
   input logic              dst_beat,
   input logic              blk_done,
   input logic              blk_err,
   input logic [CNT_W-1:0]  blk_size,
   input logic              rd_en,
   input logic [WORD_W-1:0] rd_data,
   input logic              blk_active,
   input logic [CNT_W-1:0]  count,
   input logic [RES_W-1:0]  residue
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [WORD_W-1:0] FIELD_MASK =
      ({{(WORD_W-CNT_W){1'b0}}, {CNT_W{1'b1}}} << CNT_LSB) |
      ({{(WORD_W-RES_W){1'b0}}, {RES_W{1'b1}}} << RES_LSB);

   p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~FIELD_MASK) == '0);

   p_clear_on_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_en) |=> (count == '0) && (residue == '0));

   p_done_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_active && blk_done && !blk_err) |=> (count == $past(blk_size)) && (residue == '0));

   p_err_keeps_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_active && blk_err) |=> $stable(count));

   p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!blk_active && $stable(ch_en)) |=> $stable(count) && $stable(residue));

   p_read_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> (rd_data[CNT_LSB +: CNT_W] == $past(count)) &&
                (rd_data[RES_LSB +: RES_W] == $past(residue)));

   p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   generate
      if (SATURATE) begin : g_sat_chk
         p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (blk_active && dst_beat && !blk_err && !blk_done && (count == CNT_MAX))
               |=> (count == CNT_MAX));
      end
   endgenerate
endmodule

bind dma_xfer_status dma_xfer_status_chk #(
   .WORD_W(WORD_W), .CNT_W(CNT_W), .RES_W(RES_W),
   .CNT_LSB(CNT_LSB), .RES_LSB(RES_LSB), .SATURATE(SATURATE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .dst_beat(dst_beat),
   .blk_done(blk_done), .blk_err(blk_err), .blk_size(blk_size),
   .rd_en(rd_en), .rd_data(rd_data), .blk_active(blk_active),
   .count(count), .residue(residue)
);

// File: tb/dma_xfer_status_tb.sv
module dma_xfer_status_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SAT_W      = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ch_en = 1'b0;
   logic        dst_beat = 1'b0;
   logic        blk_done = 1'b0;
   logic        blk_err = 1'b0;
   logic [21:0] blk_size = '0;
   logic [17:0] fifo_bytes = '0;
   logic [2:0]  src_wcode = '0;
   logic [2:0]  dst_wcode = '0;
   logic        rd_en = 1'b0;
   logic [63:0] rd_data;
   logic [63:0] rd_data_sat;

   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_xfer_status u_dut (
      .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .dst_beat(dst_beat),
      .blk_done(blk_done), .blk_err(blk_err), .blk_size(blk_size),
      .fifo_bytes(fifo_bytes), .src_wcode(src_wcode), .dst_wcode(dst_wcode),
      .rd_en(rd_en), .rd_data(rd_data)
   );

   dma_xfer_status #(.CNT_W(SAT_W)) u_dut_sat (
      .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .dst_beat(dst_beat),
      .blk_done(blk_done), .blk_err(blk_err), .blk_size(blk_size[SAT_W-1:0]),
      .fifo_bytes(fifo_bytes), .src_wcode(src_wcode), .dst_wcode(dst_wcode),
      .rd_en(rd_en), .rd_data(rd_data_sat)
   );

   // scoreboard
   logic [63:0] exp_q[$];
   string       tag_q[$];
   logic        rd_pend = 1'b0;

   always @(posedge clk) rd_pend <= rd_en;

   always @(negedge clk) begin
      if (rd_pend && exp_q.size() > 0) begin
         logic [63:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (rd_data !== e) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, rd_data, e);
         end
      end
   end

   function automatic logic [63:0] mk(input logic [21:0] c, input logic [14:0] r);
      mk = {17'd0, r, 10'd0, c};
   endfunction

   task automatic check_val(input string t, input logic [63:0] act, input logic [63:0] e);
      checks++;
      if (act !== e) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", t, act, e);
      end
   endtask

   task automatic rd(input logic [63:0] e, input string t);
      @(negedge clk);
      rd_en = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic start_blk();
      @(negedge clk);
      ch_en = 1'b0;
      @(negedge clk);
      ch_en = 1'b1;
   endtask

   task automatic beats(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         dst_beat = 1'b1;
      end
      @(negedge clk);
      dst_beat = 1'b0;
   endtask

   task automatic end_blk(input bit err, input bit done, input bit beat,
                          input logic [21:0] sz, input logic [17:0] fb,
                          input logic [2:0] sw, input logic [2:0] dw);
      @(negedge clk);
      blk_err = err; blk_done = done; dst_beat = beat;
      blk_size = sz; fifo_bytes = fb; src_wcode = sw; dst_wcode = dw;
      @(negedge clk);
      blk_err = 1'b0; blk_done = 1'b0; dst_beat = 1'b0;
   endtask

   initial begin
      logic [63:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd(mk(0, 0), "R1 R2 reset word zero");

      // normal block: count forced to block size, residue zero
      start_blk();
      beats(10);
      end_blk(1'b0, 1'b1, 1'b0, 22'd12, 18'd40, 3'd2, 3'd2);
      rd(mk(12, 0), "R5 normal done size and zero residue");

      // ignored stimulus while idle
      beats(5);
      end_blk(1'b1, 1'b0, 1'b1, 22'd99, 18'd64, 3'd0, 3'd0);
      rd(mk(12, 0), "R8 idle beats/err ignored");

      // clear on enable, error end
      start_blk();
      rd(mk(0, 0), "R2 clear on enable");
      beats(7);
      end_blk(1'b1, 1'b0, 1'b1, 22'd50, 18'd40, 3'd2, 3'd2);
      rd(mk(7, 10), "R6 R3 error partial count and residue");

      // mid-block count, then simultaneous done+err
      start_blk();
      beats(3);
      rd(mk(3, 0), "R3 mid-block count");
      beats(2);
      end_blk(1'b1, 1'b1, 1'b0, 22'd20, 18'd9, 3'd0, 3'd0);
      rd(mk(5, 9), "R6 error wins over done");

      // done after end has no effect
      end_blk(1'b0, 1'b1, 1'b0, 22'd33, 18'd0, 3'd0, 3'd0);
      rd(mk(5, 9), "R8 done after end ignored");

      // fragment smaller than a source item
      start_blk();
      beats(4);
      end_blk(1'b1, 1'b0, 1'b0, 22'd8, 18'd5, 3'd3, 3'd4);
      rd(mk(4, 0), "R7 fragment reads zero");

      // residue clamp and reserved bits
      start_blk();
      beats(1);
      end_blk(1'b1, 1'b0, 1'b0, 22'd8, 18'h3FFFF, 3'd0, 3'd0);
      rd(mk(1, 15'h7FFF), "R7 R1 residue clamp reserved zero");

      // read holds without a request
      @(negedge clk);
      held = rd_data;
      start_blk();
      beats(3);
      @(negedge clk);
      check_val("R9 rd_data holds without rd_en", rd_data, held);

      // enable drop ends the block
      @(negedge clk);
      ch_en = 1'b0;
      beats(4);
      rd(mk(3, 0), "R8 enable drop ends block");

      // saturation on narrow instance
      start_blk();
      beats(70);
      rd(mk(70, 0), "R3 long block count");
      check_val("R4 narrow counter saturates", rd_data_sat,
                {17'd0, 15'd0, 26'd0, 6'h3F});

      repeat (4) @(negedge clk);
      done_flag = 1'b1;
   end

   initial begin
      fork
         wait (done_flag);
         begin
            repeat (20000) @(posedge clk);
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule